// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

The block collects up to 32 interrupt lines and forwards them to a processor on two outputs: a normal interrupt and a fast interrupt. Each line has a configuration word that picks its sensitivity (edge or level), its class (normal or fast) and a 5-bit priority. A per-line mask blocks lines from reaching either output. Software programs the block and services it through a word-wide register port. A bus request is one cycle with `bus_valid` high. Write effects take hold at the clock edge that ends the request. Read data is combinational during the request cycle.

Each output has its own arbitration-enable flag. When that flag is set and an unmasked pending line of the output's class exists, the output rises, the flag clears, and the number of the winning line is captured. The output then stays high, and the captured number stays fixed, until software re-arms the class through the control register. Reading a class's index register returns the captured number. If that line is edge sensitive, the read also acknowledges it. Software can raise a line through the software-set register. It can drop pending bits through the pending register, but a level line whose input is still asserted keeps its pending bit.

Register offsets (byte addresses, word aligned):

| Offset | Function |
|---|---|
| 0x00 | pending bits (read / AND-write) |
| 0x04 | mask bits, 1 = blocked |
| 0x10 | normal-class captured index (read only) |
| 0x14 | fast-class captured index (read only) |
| 0x18 | control (write only, reads zero) |
| 0x1C + 4·n | configuration word of line n |
| 0x9C | software set (write only, reads zero) |

Top module: `edge_level_intc`

## Requirements
- R1: After reset, the mask reads 0xFFFFFFFF, and the pending register, every configuration word and both index registers read zero. Both outputs are low.
- R2: The configuration word of line n sits at 0x1C+4·n. Bits [6:2] hold the priority, bit 1 holds the sensitivity (1 = level, 0 = edge) and bit 0 holds the class (1 = fast, 0 = normal). A read returns these seven bits, and bits [31:7] read zero.
- R3: An edge line becomes pending in the cycle after its input goes from low to high. A steady-high input does not set it again after it is cleared, and the bit stays set when the input falls.
- R4: A level line is pending while its input is high. Its pending bit clears in the cycle after its input falls.
- R5: A write to 0x00 keeps only the pending bits that are 1 in the written value, except that a level line with its input high keeps its pending bit.
- R6: An output rises only when its arbitration-enable flag is set and an unmasked pending line of its class exists. It then stays high, with its index fixed, until its class is re-armed.
- R7: A control write with bit 0 set drops the normal output on the next edge and sets its flag. Bit 1 does the same for the fast output. Arbitration resumes on the following edge.
- R8: The winner is the qualifying line with the smallest priority value. When priorities are equal, the highest line number wins.
- R9: A read of 0x10 or 0x14 returns the captured index in bits [4:0] and clears that line's pending bit when the line is edge sensitive. A level line's pending bit is left untouched.
- R10: A write to 0x9C makes pending only the lowest set bit of the written value.
- R11: A write to 0x04 replaces the mask, and the new mask first takes part in arbitration at the clock edge after the write.
- R12: Reads of undefined offsets, of control and of the software-set register return zero. Writes to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 32 | Interrupt inputs, high = asserted |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the request cycle |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
The hardest case to reach is arbitration among several lines that are already pending when they first become eligible. Lines raised one after another would each win in turn as they arrive. The bench therefore raises three edge lines while the mask blocks all of them, which also shows that nothing escapes a closed mask. It then opens the mask with a single write and checks that the output is still low one edge later and high after that. Each winner is acknowledged and the class re-armed, so the priority order and the tie rule that favours the higher line number show up in three successive index reads.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [7:0] OFF_PEND    = 8'h00;
   localparam logic [7:0] OFF_MASK    = 8'h04;
   localparam logic [7:0] OFF_IDX_IRQ = 8'h10;
   localparam logic [7:0] OFF_IDX_FIQ = 8'h14;
   localparam logic [7:0] OFF_CTRL    = 8'h18;
   localparam logic [7:0] OFF_CFG     = 8'h1C;
   localparam logic [7:0] OFF_SWSET   = 8'h9C;
   localparam int         CLS_IRQ     = 0;
   localparam int         CLS_FIQ     = 1;
   localparam int         NUM_CLS     = 2;
endpackage

// File: rtl/intc_capture.sv
// Per-line pending state: edge/level capture, software set, clears.
// Clears are applied after sets within one cycle.
module intc_capture #(
   parameter int NLINES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] line_in,
   input  logic [NLINES-1:0] level_cfg,
   input  logic [NLINES-1:0] sw_set,
   input  logic              wclr_en,
   input  logic [NLINES-1:0] wclr_keep,
   input  logic [NLINES-1:0] ack_clr,
   output logic [NLINES-1:0] pend_q,
   output logic [NLINES-1:0] in_q
);
   logic [NLINES-1:0] rise, fall, set_v, clr_v, pend_d;

   always_comb begin
      rise  = line_in & ~in_q;
      fall  = in_q & ~line_in;
      set_v = (rise & ~level_cfg) | (line_in & level_cfg) | sw_set;
      clr_v = (fall & level_cfg) | ack_clr;
      if (wclr_en)
         clr_v = clr_v | ~(wclr_keep | (level_cfg & line_in));
      pend_d = (pend_q | set_v) & ~clr_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         in_q   <= '0;
      end else begin
         pend_q <= pend_d;
         in_q   <= line_in;
      end
   end
endmodule

// File: rtl/intc_select.sv
// Priority scan: lowest value wins, later (higher) index wins ties.
module intc_select #(
   parameter int NLINES = 32,
   parameter int PRIO_W = 5,
   localparam int IDX_W = $clog2(NLINES)
) (
   input  logic [NLINES-1:0]             qual,
   input  logic [NLINES-1:0][PRIO_W-1:0] prio,
   output logic                          found,
   output logic [IDX_W-1:0]              winner
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      found  = 1'b0;
      winner = '0;
      best   = '1;
      for (int i = 0; i < NLINES; i++) begin
         if (qual[i] && prio[i] <= best) begin
            found  = 1'b1;
            best   = prio[i];
            winner = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/intc_gate.sv
// One output class: arbitration-enable flag, sticky output, captured index.
module intc_gate #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rearm,
   input  logic             found,
   input  logic [IDX_W-1:0] winner,
   output logic             out_q,
   output logic             agree_q,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         agree_q <= 1'b1;
         out_q   <= 1'b0;
         idx_q   <= '0;
      end else if (rearm) begin
         agree_q <= 1'b1;
         out_q   <= 1'b0;
      end else if (agree_q && found) begin
         agree_q <= 1'b0;
         out_q   <= 1'b1;
         idx_q   <= winner;
      end
   end
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
   import intc_pkg::*;
#(
   parameter int NLINES = 32,
   parameter int PRIO_W = 5,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] line_in,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int IDX_W  = $clog2(NLINES);
   localparam int CFG_W  = PRIO_W + 2;
   localparam int WORD_W = ADDR_W - 2;

   if (NLINES < 2 || NLINES > 32) begin : g_bad_lines
      $error("NLINES must lie in 2..32");
   end
   if (DATA_W != 32 || ADDR_W < 8) begin : g_bad_bus
      $error("bus must be 32 bits wide with at least 8 address bits");
   end
   if (CFG_W > DATA_W || PRIO_W < 1) begin : g_bad_prio
      $error("priority field does not fit the configuration word");
   end

   logic wr, rd;
   logic [WORD_W-1:0] cfg_word;
   logic cfg_hit;
   logic [IDX_W-1:0] cfg_idx;

   assign wr       = bus_valid & bus_write;
   assign rd       = bus_valid & ~bus_write;
   assign cfg_word = bus_addr[ADDR_W-1:2] - WORD_W'(OFF_CFG >> 2);
   assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (cfg_word < WORD_W'(NLINES));
   assign cfg_idx  = cfg_word[IDX_W-1:0];

   // configuration and mask storage
   logic [NLINES-1:0][PRIO_W-1:0] prio_q;
   logic [NLINES-1:0] level_q, fiq_q, mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q  <= '0;
         level_q <= '0;
         fiq_q   <= '0;
         mask_q  <= '1;
      end else if (wr) begin
         if (bus_addr == ADDR_W'(OFF_MASK))
            mask_q <= bus_wdata[NLINES-1:0];
         for (int i = 0; i < NLINES; i++) begin
            if (cfg_hit && cfg_idx == IDX_W'(i)) begin
               prio_q[i]  <= bus_wdata[CFG_W-1:2];
               level_q[i] <= bus_wdata[1];
               fiq_q[i]   <= bus_wdata[0];
            end
         end
      end
   end

   // pending capture
   logic [NLINES-1:0] pend_q, in_q, sw_set, ack_clr;
   logic [NUM_CLS-1:0][IDX_W-1:0] idx_q;
   logic wclr_en;

   assign wclr_en = wr && (bus_addr == ADDR_W'(OFF_PEND));
   assign sw_set  = (wr && bus_addr == ADDR_W'(OFF_SWSET)) ?
                    (bus_wdata[NLINES-1:0] & (~bus_wdata[NLINES-1:0] + 1'b1)) : '0;

   always_comb begin
      ack_clr = '0;
      if (rd && bus_addr == ADDR_W'(OFF_IDX_IRQ))
         ack_clr = ack_clr | (NLINES'(1) << idx_q[CLS_IRQ]);
      if (rd && bus_addr == ADDR_W'(OFF_IDX_FIQ))
         ack_clr = ack_clr | (NLINES'(1) << idx_q[CLS_FIQ]);
      ack_clr = ack_clr & ~level_q;
   end

   intc_capture #(.NLINES(NLINES)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_in),
      .level_cfg (level_q),
      .sw_set    (sw_set),
      .wclr_en   (wclr_en),
      .wclr_keep (bus_wdata[NLINES-1:0]),
      .ack_clr   (ack_clr),
      .pend_q    (pend_q),
      .in_q      (in_q)
   );

   // per-class arbitration and output gating
   logic [NUM_CLS-1:0][NLINES-1:0] qual;
   logic [NUM_CLS-1:0] found, rearm, out_q, agree_q;
   logic [NUM_CLS-1:0][IDX_W-1:0] winner;

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      assign qual[c]  = pend_q & ~mask_q & ((c == CLS_FIQ) ? fiq_q : ~fiq_q);
      assign rearm[c] = wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[c];

      intc_select #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_select (
         .qual   (qual[c]),
         .prio   (prio_q),
         .found  (found[c]),
         .winner (winner[c])
      );

      intc_gate #(.IDX_W(IDX_W)) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .rearm   (rearm[c]),
         .found   (found[c]),
         .winner  (winner[c]),
         .out_q   (out_q[c]),
         .agree_q (agree_q[c]),
         .idx_q   (idx_q[c])
      );
   end

   assign irq_o = out_q[CLS_IRQ];
   assign fiq_o = out_q[CLS_FIQ];

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_PEND))
         bus_rdata[NLINES-1:0] = pend_q;
      else if (bus_addr == ADDR_W'(OFF_MASK))
         bus_rdata[NLINES-1:0] = mask_q;
      else if (bus_addr == ADDR_W'(OFF_IDX_IRQ))
         bus_rdata[IDX_W-1:0] = idx_q[CLS_IRQ];
      else if (bus_addr == ADDR_W'(OFF_IDX_FIQ))
         bus_rdata[IDX_W-1:0] = idx_q[CLS_FIQ];
      else if (cfg_hit)
         bus_rdata[CFG_W-1:0] = {prio_q[cfg_idx], level_q[cfg_idx], fiq_q[cfg_idx]};
   end
endmodule

// File: rtl/edge_level_intc_chk.sv
module edge_level_intc_chk
   import intc_pkg::*;
#(
   parameter int NLINES = 32,
   parameter int ADDR_W = 8,
   localparam int IDX_W = $clog2(NLINES)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_valid,
   input logic                           bus_write,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic [1:0]                     ctl_bits,
   input logic [NLINES-1:0]              line_in,
   input logic [NLINES-1:0]              in_q,
   input logic [NLINES-1:0]              pend_q,
   input logic [NLINES-1:0]              level_q,
   input logic [NUM_CLS-1:0]             agree_q,
   input logic [NUM_CLS-1:0][IDX_W-1:0]  idx_q,
   input logic                           irq_o,
   input logic                           fiq_o
);
   logic ctl_wr, rearm_irq, rearm_fiq, rd_idx_irq;

   assign ctl_wr     = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_CTRL));
   assign rearm_irq  = ctl_wr && ctl_bits[0];
   assign rearm_fiq  = ctl_wr && ctl_bits[1];
   assign rd_idx_irq = bus_valid && !bus_write && (bus_addr == ADDR_W'(OFF_IDX_IRQ));

   assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(agree_q[CLS_IRQ]));

   assert_fiq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fiq_o) |-> $past(agree_q[CLS_FIQ]));

   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !rearm_irq) |=> irq_o);

   assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_irq |=> !irq_o);

   assert_fiq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_fiq |=> !fiq_o);

   assert_level_fall_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(level_q & in_q & ~line_in)) |=> ((pend_q & $past(level_q & in_q & ~line_in)) == '0));

   assert_edge_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx_irq && !level_q[idx_q[CLS_IRQ]]) |=> !pend_q[$past(idx_q[CLS_IRQ])]);
endmodule

bind edge_level_intc edge_level_intc_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .ctl_bits  (bus_wdata[1:0]),
   .line_in   (line_in),
   .in_q      (in_q),
   .pend_q    (pend_q),
   .level_q   (level_q),
   .agree_q   (agree_q),
   .idx_q     (idx_q),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o)
);

// File: tb/test_edge_level_intc.sv
`timescale 1ns/1ps
module test_edge_level_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] line_in = '0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;
   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   edge_level_intc i_edge_level_intc (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   // {write, addr, data-or-expected}
   localparam logic [40:0] TBL [11] = '{
      {1'b1, 8'h28, 32'h0000_007F},   // R2 line 3
      {1'b0, 8'h28, 32'h0000_007F},
      {1'b1, 8'h98, 32'hFFFF_FFFF},   // R2 line 31, upper bits dropped
      {1'b0, 8'h98, 32'h0000_007F},
      {1'b1, 8'h04, 32'h1234_5678},   // R11 mask readback
      {1'b0, 8'h04, 32'h1234_5678},
      {1'b1, 8'h08, 32'hFFFF_FFFF},   // R12 undefined offset
      {1'b0, 8'h08, 32'h0000_0000},
      {1'b0, 8'h18, 32'h0000_0000},   // R12 control reads zero
      {1'b0, 8'h9C, 32'h0000_0000},   // R12 software set reads zero
      {1'b0, 8'h1C, 32'h0000_0000}    // R2 line 0 untouched
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 irq", {31'b0, irq_o}, 0);
      chk("R1 fiq", {31'b0, fiq_o}, 0);
      rd(8'h00, rv); chk("R1 pending", rv, 32'h0);
      rd(8'h04, rv); chk("R1 mask", rv, 32'hFFFF_FFFF);
      rd(8'h30, rv); chk("R1 config", rv, 32'h0);
      rd(8'h10, rv); chk("R1 index", rv, 32'h0);

      // table walk: R2, R11, R12
      for (int k = 0; k < 11; k++) begin
         if (TBL[k][40]) wr(TBL[k][39:32], TBL[k][31:0]);
         else begin
            rd(TBL[k][39:32], rv);
            chk("R2/R11/R12 table", rv, TBL[k][31:0]);
         end
      end
      wr(8'h28, 0); wr(8'h98, 0); wr(8'h04, 32'hFFFF_FFFF);
      chk("R12 no output after stray writes", {30'b0, fiq_o, irq_o}, 0);

      // edge line 4
      wr(8'h04, 32'hFFFF_FFEF);
      @(negedge clk) line_in[4] = 1'b1;
      idle(3);
      chk("R6 irq rises", {31'b0, irq_o}, 1);
      chk("R6 fiq quiet", {31'b0, fiq_o}, 0);
      rd(8'h00, rv); chk("R3 edge pending", rv, 32'h10);
      rd(8'h10, rv); chk("R9 index", rv, 4);
      rd(8'h00, rv); chk("R3 R9 acked, no re-pend while high", rv, 0);
      chk("R6 irq sticky", {31'b0, irq_o}, 1);
      wr(8'h18, 1); idle(1);
      chk("R7 irq dropped", {31'b0, irq_o}, 0);
      @(negedge clk) line_in[4] = 1'b0;
      idle(2);
      @(negedge clk) line_in[4] = 1'b1;
      @(negedge clk) line_in[4] = 1'b0;
      idle(3);
      rd(8'h00, rv); chk("R3 kept after fall", rv, 32'h10);
      chk("R7 re-armed output rises", {31'b0, irq_o}, 1);
      wr(8'h00, 0);
      rd(8'h00, rv); chk("R5 edge cleared by write", rv, 0);
      wr(8'h18, 1); idle(2);
      chk("R7 irq low", {31'b0, irq_o}, 0);

      // level line 7
      wr(8'h38, 32'h2);
      wr(8'h04, 32'hFFFF_FF6F);
      @(negedge clk) line_in[7] = 1'b1;
      idle(3);
      rd(8'h00, rv); chk("R4 level pending", rv, 32'h80);
      wr(8'h00, 0);
      rd(8'h00, rv); chk("R5 level protected", rv, 32'h80);
      rd(8'h10, rv); chk("R9 level index", rv, 7);
      rd(8'h00, rv); chk("R9 level not acked", rv, 32'h80);
      @(negedge clk) line_in[7] = 1'b0;
      idle(2);
      rd(8'h00, rv); chk("R4 cleared on fall", rv, 0);
      wr(8'h18, 1); idle(2);

      // priority among lines 10 (p3), 12 (p1), 20 (p1)
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h44, 32'h0C); wr(8'h4C, 32'h04); wr(8'h6C, 32'h04);
      @(negedge clk) begin line_in[10] = 1'b1; line_in[12] = 1'b1; line_in[20] = 1'b1; end
      idle(3);
      rd(8'h00, rv); chk("R3 three pending", rv, 32'h0010_1400);
      chk("R6 masked stays low", {31'b0, irq_o}, 0);
      wr(8'h04, 32'hFFEF_EBFF);
      chk("R11 not yet", {31'b0, irq_o}, 0);
      idle(1);
      chk("R11 next cycle", {31'b0, irq_o}, 1);
      rd(8'h10, rv); chk("R8 tie to higher line", rv, 20);
      wr(8'h18, 1); idle(2);
      rd(8'h10, rv); chk("R8 priority 1", rv, 12);
      wr(8'h18, 1); idle(2);
      rd(8'h10, rv); chk("R8 priority 3", rv, 10);
      wr(8'h18, 1); idle(2);
      chk("R7 nothing left", {31'b0, irq_o}, 0);
      @(negedge clk) line_in = '0;

      // fast class, software set of lowest bit
      wr(8'h58, 32'h1);
      wr(8'h04, 32'hFFFE_7FFF);
      wr(8'h9C, 32'h0001_8000);
      idle(3);
      rd(8'h00, rv); chk("R10 lowest bit only", rv, 32'h8000);
      chk("R6 fiq rises", {31'b0, fiq_o}, 1);
      chk("R6 irq quiet", {31'b0, irq_o}, 0);
      rd(8'h14, rv); chk("R9 fiq index", rv, 15);
      rd(8'h00, rv); chk("R9 fiq acked", rv, 0);
      wr(8'h18, 2); idle(2);
      chk("R7 fiq dropped", {31'b0, fiq_o}, 0);

      finish_run();
   end
endmodule